// File: doc/BRIEF.md
# SRAM Bus Timing Checker

This block watches the pins of an asynchronous 16-bit static RAM bus from the side and does not drive them. It samples the chip select, write enable, output enable, the two byte selects, the address and the data lines with a fast local clock. From those samples it decides what kind of access the bus is doing, and it measures the intervals that matter for a correct write or read by counting sample cycles. When an interval is shorter than its configured minimum, it sets a sticky error bit for that rule. It also keeps running counts of completed reads and writes.

All bus inputs pass together through a two-flop synchronizer. Every interval is taken between edges of the synchronized copies, so the shared latency cancels out of the measurement. The class output trails the bus by two sample cycles, and errors and counts trail it by three. Minimum intervals are parameters given in sample cycles. The defaults suit a 10 ns sample clock and the fastest access grade.

Top module: `srmon_top`

## Requirements
- R1: The class output is 0 (standby) whenever chip select is high, or when both byte selects are high. Output enable is ignored in that case.
- R2: With chip select low, write enable high and output enable high, the class is 1 (outputs disabled).
- R3: With chip select low, write enable high and output enable low, the class is 2 when both byte selects are low, 3 when only the lower select is low, and 4 when only the upper select is low.
- R4: With chip select low and write enable low, the class is 5, 6 or 7, split by the byte selects in the same way as R3. Output enable has no effect on the class.
- R5: A write is active while the class is 5 to 7. It starts on the last strobe to fall and ends on the first strobe to rise. If the active stretch lasts fewer than MIN_WP samples, error bit 0 is set.
- R6: If two successive write starts are fewer than MIN_WC samples apart, error bit 1 is set.
- R7: If the data lines have been stable for fewer than MIN_DS samples when a write ends, error bit 2 is set.
- R8: If the address has been stable for fewer than MIN_AW samples when a write ends, error bit 3 is set.
- R9: If the byte selects have been stable for fewer than MIN_BW samples when a write ends, error bit 4 is set.
- R10: Within one continuous read, the first address change starts the measurement. Each later address change that comes fewer than MIN_RC samples after the previous one sets error bit 5.
- R11: Error bits stay set until clr_err is sampled high, which clears them on the next edge. A violation detected in that same cycle still sets its bit.
- R12: wr_count increases by one at each write end.
- R13: rd_count increases by one when the class leaves the read group (2 to 4), and on each address change during a read. A change between read classes is not counted.
- R14: After reset, the class is 0 (standby), all error bits are 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears all sticky error bits |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_lb_n | input | 1 | Bus lower byte select, active low |
| bus_ub_n | input | 1 | Bus upper byte select, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data lines as seen by the monitor |
| op_class | output | 3 | Current access class (R1 to R4) |
| err_flags | output | 6 | Sticky timing error bits (R5 to R10) |
| rd_count | output | CNT_W | Completed read count, wraps |
| wr_count | output | CNT_W | Completed write count, wraps |

## Verification
The decoder is walked through every strobe combination with output enable toggled in the cases where it must not matter. This separates standby from output-disable, and each read width from each write width. Clean writes of every width, each started by a different strobe transition, show that legal timing raises no flag. Each timing rule is then broken alone, by exactly one or two samples, while every other interval is kept long, so each error bit is tied to its own rule. Two read sequences that differ only in how long one address is held separate a legal read cycle from a short one, and both exercise the read count.

// File: rtl/srmon_pkg.sv
// Shared types and indices for the SRAM bus timing checker.
// Assumes the class encoding below is visible at the top-level port.
package srmon_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_NODRV = 3'd1,
        OP_RD_W  = 3'd2,
        OP_RD_L  = 3'd3,
        OP_RD_H  = 3'd4,
        OP_WR_W  = 3'd5,
        OP_WR_L  = 3'd6,
        OP_WR_H  = 3'd7
    } op_e;

    // Error bit positions, one per timing rule.
    localparam int RULE_PULSE  = 0;
    localparam int RULE_CYCLE  = 1;
    localparam int RULE_DSETUP = 2;
    localparam int RULE_ASETUP = 3;
    localparam int RULE_BSETUP = 4;
    localparam int RULE_RDCYC  = 5;
    localparam int NUM_RULES   = 6;

    // Age tracker slots.
    localparam int AGE_STROBE = 0;
    localparam int AGE_ADDR   = 1;
    localparam int AGE_DATA   = 2;
    localparam int AGE_BSEL   = 3;
    localparam int AGE_N      = 4;

    function automatic logic is_rd(op_e c);
        return (c == OP_RD_W) || (c == OP_RD_L) || (c == OP_RD_H);
    endfunction

    function automatic logic is_wr(op_e c);
        return (c == OP_WR_W) || (c == OP_WR_L) || (c == OP_WR_H);
    endfunction

endpackage

// File: rtl/srmon_sync.sv
// Two-flop synchronizer for a vector of asynchronous bus samples.
// Assumes all bits share one latency; multi-bit skew is tolerated because
// only stable intervals of several samples are judged downstream.
module srmon_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage1;

    // Capture then re-register the raw bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_out  <= RST_VAL;
        end else begin
            stage1 <= d_in;
            q_out  <= stage1;
        end
    end
endmodule

// File: rtl/srmon_decode.sv
// Combinational access classifier for the synchronized strobes.
// Assumes strobes are active low; standby wins over every other class.
module srmon_decode
    import srmon_pkg::*;
(
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic lb_n,
    input  logic ub_n,
    output op_e  cls
);
    // Priority decode: standby, then write, then output-disable, then read.
    always_comb begin
        if (ce_n || (lb_n && ub_n)) begin
            cls = OP_IDLE;
        end else if (!we_n) begin
            if (!lb_n && !ub_n)  cls = OP_WR_W;
            else if (!lb_n)      cls = OP_WR_L;
            else                 cls = OP_WR_H;
        end else if (oe_n) begin
            cls = OP_NODRV;
        end else begin
            if (!lb_n && !ub_n)  cls = OP_RD_W;
            else if (!lb_n)      cls = OP_RD_L;
            else                 cls = OP_RD_H;
        end
    end
endmodule

// File: rtl/srmon_age.sv
// Saturating age counter: samples elapsed since the last marked event.
// Assumes reset means "event long ago", so it resets to the saturated value.
module srmon_age #(
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // Restart at one after a mark, otherwise count up and hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= AGE_MAX;
        else if (mark)           age <= AGE_W'(1);
        else if (age != AGE_MAX) age <= age + AGE_W'(1);
    end
endmodule

// File: rtl/srmon_top.sv
// SRAM bus timing checker top level.
// Synchronizes the bus and classifies each sample. It measures the write
// pulse, write cycle, data/address/byte-select setup to write end and the
// read cycle in sample counts. Violations set sticky bits; completed reads
// and writes are counted. Assumes MIN_* limits fit in AGE_W bits.
module srmon_top
    import srmon_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int AGE_W  = 8,
    parameter int MIN_WP = 4,
    parameter int MIN_WC = 6,
    parameter int MIN_DS = 3,
    parameter int MIN_AW = 5,
    parameter int MIN_BW = 5,
    parameter int MIN_RC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_err,
    input  logic                 bus_ce_n,
    input  logic                 bus_we_n,
    input  logic                 bus_oe_n,
    input  logic                 bus_lb_n,
    input  logic                 bus_ub_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    output logic [2:0]           op_class,
    output logic [NUM_RULES-1:0] err_flags,
    output logic [CNT_W-1:0]     rd_count,
    output logic [CNT_W-1:0]     wr_count
);
    localparam int SW = 5 + ADDR_W + DATA_W;
    localparam logic [AGE_W-1:0] LIM_WP = AGE_W'(MIN_WP);
    localparam logic [AGE_W-1:0] LIM_WC = AGE_W'(MIN_WC);
    localparam logic [AGE_W-1:0] LIM_DS = AGE_W'(MIN_DS);
    localparam logic [AGE_W-1:0] LIM_AW = AGE_W'(MIN_AW);
    localparam logic [AGE_W-1:0] LIM_BW = AGE_W'(MIN_BW);
    localparam logic [AGE_W-1:0] LIM_RC = AGE_W'(MIN_RC);

    logic [SW-1:0]     raw_vec, syn_vec;
    logic              s_ce_n, s_we_n, s_oe_n, s_lb_n, s_ub_n;
    logic [ADDR_W-1:0] s_addr, p_addr;
    logic [DATA_W-1:0] s_data, p_data;
    logic [1:0]        p_bsel;
    op_e               cls, cls_q;

    assign raw_vec = {bus_ce_n, bus_we_n, bus_oe_n, bus_lb_n, bus_ub_n, bus_addr, bus_data};

    srmon_sync #(.W(SW), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_vec),
        .q_out (syn_vec)
    );

    assign {s_ce_n, s_we_n, s_oe_n, s_lb_n, s_ub_n, s_addr, s_data} = syn_vec;

    srmon_decode u_dec (
        .ce_n (s_ce_n),
        .we_n (s_we_n),
        .oe_n (s_oe_n),
        .lb_n (s_lb_n),
        .ub_n (s_ub_n),
        .cls  (cls)
    );

    // Previous-sample copies used for edge and change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= OP_IDLE;
            p_addr <= '1;
            p_data <= '1;
            p_bsel <= '1;
        end else begin
            cls_q  <= cls;
            p_addr <= s_addr;
            p_data <= s_data;
            p_bsel <= {s_lb_n, s_ub_n};
        end
    end

    logic wr_now, wr_prv, rd_now, rd_prv;
    logic wr_start, wr_end;
    logic addr_chg, data_chg, bsel_chg;

    assign wr_now   = is_wr(cls);
    assign wr_prv   = is_wr(cls_q);
    assign rd_now   = is_rd(cls);
    assign rd_prv   = is_rd(cls_q);
    assign wr_start = wr_now && !wr_prv;
    assign wr_end   = wr_prv && !wr_now;
    assign addr_chg = (s_addr != p_addr);
    assign data_chg = (s_data != p_data);
    assign bsel_chg = ({s_lb_n, s_ub_n} != p_bsel);

    logic [AGE_N-1:0] age_mark;
    logic [AGE_W-1:0] age_val [AGE_N];

    assign age_mark[AGE_STROBE] = wr_start;
    assign age_mark[AGE_ADDR]   = addr_chg;
    assign age_mark[AGE_DATA]   = data_chg;
    assign age_mark[AGE_BSEL]   = bsel_chg;

    for (genvar gi = 0; gi < AGE_N; gi++) begin : g_age
        srmon_age #(.AGE_W(AGE_W)) u_age (
            .clk   (clk),
            .rst_n (rst_n),
            .mark  (age_mark[gi]),
            .age   (age_val[gi])
        );
    end

    // Marks that the current read has already seen one address change.
    logic rd_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                       rd_run <= 1'b0;
        else if (!rd_now)                 rd_run <= 1'b0;
        else if (rd_prv && addr_chg)      rd_run <= 1'b1;
    end

    logic                 rd_addr_step, rd_done;
    logic [NUM_RULES-1:0] viol;

    assign rd_addr_step = rd_now && rd_prv && addr_chg;
    assign rd_done      = (rd_prv && !rd_now) || rd_addr_step;

    // Rule evaluation at the write start, write end and read address steps.
    always_comb begin
        viol               = '0;
        viol[RULE_PULSE]   = wr_end   && (age_val[AGE_STROBE] < LIM_WP);
        viol[RULE_CYCLE]   = wr_start && (age_val[AGE_STROBE] < LIM_WC);
        viol[RULE_DSETUP]  = wr_end   && (age_val[AGE_DATA]   < LIM_DS);
        viol[RULE_ASETUP]  = wr_end   && (age_val[AGE_ADDR]   < LIM_AW);
        viol[RULE_BSETUP]  = wr_end   && (age_val[AGE_BSEL]   < LIM_BW);
        viol[RULE_RDCYC]   = rd_addr_step && rd_run && (age_val[AGE_ADDR] < LIM_RC);
    end

    // Sticky error bits: a new violation wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flags <= '0;
        else        err_flags <= (clr_err ? '0 : err_flags) | viol;
    end

    // Completed access counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= '0;
            wr_count <= '0;
        end else begin
            if (rd_done) rd_count <= rd_count + CNT_W'(1);
            if (wr_end)  wr_count <= wr_count + CNT_W'(1);
        end
    end

    assign op_class = cls;

endmodule

// File: rtl/srmon_check.sv
// Property checker for the SRAM bus timing checker, bound to the top.
// Assumes the class encoding of srmon_pkg: 2..4 reads, 5..7 writes.
module srmon_check #(
    parameter int CNT_W   = 16,
    parameter int NUM_ERR = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_err,
    input logic [2:0]         op_class,
    input logic [NUM_ERR-1:0] err_flags,
    input logic [CNT_W-1:0]   rd_count,
    input logic [CNT_W-1:0]   wr_count
);
    // R11: without a clear, no set bit may drop.
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_err) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R12: the write count moves by one, right after a write stretch ends.
    p_wr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count != $past(wr_count)) |-> (wr_count == CNT_W'($past(wr_count) + 1'b1)));
    p_wr_after_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count != $past(wr_count)) |-> (($past(op_class, 2) >= 3'd5) && ($past(op_class) < 3'd5)));

    // R13: the read count moves by one and only out of a read sample.
    p_rd_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count != $past(rd_count)) |-> (rd_count == CNT_W'($past(rd_count) + 1'b1)));
    p_rd_after_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count != $past(rd_count)) |-> (($past(op_class, 2) >= 3'd2) && ($past(op_class, 2) <= 3'd4)));

    // R5: pulse width error appears only after a write end.
    p_pulse_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[0]) |-> (($past(op_class, 2) >= 3'd5) && ($past(op_class) < 3'd5)));

    // R6: write cycle error appears only after a write start.
    p_cycle_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[1]) |-> (($past(op_class) >= 3'd5) && ($past(op_class, 2) < 3'd5)));

    // R7: data setup error appears only after a write end.
    p_data_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[2]) |-> (($past(op_class, 2) >= 3'd5) && ($past(op_class) < 3'd5)));

    // R8: address setup error appears only after a write end.
    p_addr_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[3]) |-> (($past(op_class, 2) >= 3'd5) && ($past(op_class) < 3'd5)));

    // R9: byte select setup error appears only after a write end.
    p_bsel_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[4]) |-> (($past(op_class, 2) >= 3'd5) && ($past(op_class) < 3'd5)));

    // R10: read cycle error appears only inside a read.
    p_rdcyc_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[5]) |-> (($past(op_class, 2) >= 3'd2) && ($past(op_class, 2) <= 3'd4)));

endmodule

bind srmon_top srmon_check #(.CNT_W(CNT_W), .NUM_ERR(srmon_pkg::NUM_RULES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_err   (clr_err),
    .op_class  (op_class),
    .err_flags (err_flags),
    .rd_count  (rd_count),
    .wr_count  (wr_count)
);

// File: tb/srmon_top_test.sv
// Scoreboard bench for the SRAM bus timing checker.
module srmon_top_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] C_IDLE = 3'd0, C_NODRV = 3'd1;
    localparam logic [2:0] C_RDW = 3'd2, C_RDL = 3'd3, C_RDH = 3'd4;
    localparam logic [2:0] C_WRW = 3'd5, C_WRL = 3'd6, C_WRH = 3'd7;
    localparam logic [5:0] E_NONE = 6'b000000, E_WP = 6'b000001, E_WC = 6'b000010;
    localparam logic [5:0] E_DS = 6'b000100, E_AW = 6'b001000, E_BW = 6'b010000;
    localparam logic [5:0] E_RC = 6'b100000;
    localparam logic [17:0] A0 = 18'h00000, A1 = 18'h1A5C3, A2 = 18'h02F10;
    localparam logic [15:0] D0 = 16'h0000, D1 = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_err = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [17:0] addr = A0;
    logic [15:0] data = D0;
    logic [2:0]  op_class;
    logic [5:0]  err_flags;
    logic [15:0] rd_count, wr_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    srmon_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_err   (clr_err),
        .bus_ce_n  (ce_n),
        .bus_we_n  (we_n),
        .bus_oe_n  (oe_n),
        .bus_lb_n  (lb_n),
        .bus_ub_n  (ub_n),
        .bus_addr  (addr),
        .bus_data  (data),
        .op_class  (op_class),
        .err_flags (err_flags),
        .rd_count  (rd_count),
        .wr_count  (wr_count)
    );

    typedef struct {
        string      tag;
        logic [2:0] cls;
        logic [5:0] err;
        int         rd;
        int         wr;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_rd = 0;
    int    exp_wr = 0;
    bit    done = 1'b0;

    task automatic drive(input logic c, input logic w, input logic o,
                         input logic l, input logic u,
                         input logic [17:0] a, input logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; data = d;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag, input logic [2:0] c, input logic [5:0] e);
        item_t it;
        it.tag = tag; it.cls = c; it.err = e; it.rd = exp_rd; it.wr = exp_wr;
        sb_q.push_back(it);
        -> chk_ev;
    endtask

    task automatic clear_errs(input string tag);
        clr_err = 1'b1;
        hold(1);
        clr_err = 1'b0;
        hold(2);
        expect_now(tag, C_IDLE, E_NONE);
    endtask

    task automatic compare_all();
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks += 4;
            if (op_class !== it.cls) begin
                n_fail++;
                $display("FAIL %s class: actual %0d expected %0d", it.tag, op_class, it.cls);
            end
            if (err_flags !== it.err) begin
                n_fail++;
                $display("FAIL %s errors: actual %b expected %b", it.tag, err_flags, it.err);
            end
            if (int'(rd_count) != it.rd) begin
                n_fail++;
                $display("FAIL %s rd_count: actual %0d expected %0d", it.tag, rd_count, it.rd);
            end
            if (int'(wr_count) != it.wr) begin
                n_fail++;
                $display("FAIL %s wr_count: actual %0d expected %0d", it.tag, wr_count, it.wr);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            compare_all();
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            compare_all();
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    // Driver.
    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(4);
        expect_now("R14 reset state", C_IDLE, E_NONE);

        // Classification walk.
        drive(0, 1, 1, 0, 0, A0, D0); hold(4); expect_now("R2 output disable", C_NODRV, E_NONE);
        drive(0, 1, 0, 0, 0, A0, D0); hold(4); expect_now("R3 read word", C_RDW, E_NONE);
        drive(0, 1, 0, 0, 1, A0, D0); hold(4); expect_now("R3 read lower (R13 no count)", C_RDL, E_NONE);
        drive(0, 1, 0, 1, 0, A0, D0); hold(4); expect_now("R3 read upper", C_RDH, E_NONE);
        drive(0, 1, 0, 1, 1, A0, D0); exp_rd++; hold(4);
        expect_now("R1 both selects high, R13 read exit", C_IDLE, E_NONE);
        drive(1, 1, 0, 0, 0, A0, D0); hold(4); expect_now("R1 chip select high", C_IDLE, E_NONE);

        // Clean writes of each width.
        drive(0, 0, 1, 0, 0, A0, D0); hold(4); expect_now("R4 write word", C_WRW, E_NONE); hold(2);
        drive(1, 1, 1, 0, 0, A0, D0); exp_wr++; hold(5); expect_now("R12 write end count", C_IDLE, E_NONE);
        drive(0, 0, 0, 0, 1, A0, D0); hold(4); expect_now("R4 write lower, oe ignored", C_WRL, E_NONE); hold(2);
        drive(1, 1, 1, 0, 1, A0, D0); exp_wr++; hold(5); expect_now("R12 second write", C_IDLE, E_NONE);
        drive(0, 0, 1, 1, 0, A0, D0); hold(4); expect_now("R4 write upper", C_WRH, E_NONE); hold(2);
        drive(1, 1, 1, 1, 0, A0, D0); exp_wr++; hold(5);
        expect_now("R5 R6 R7 R8 R9 clean writes", C_IDLE, E_NONE);
        drive(1, 1, 1, 0, 0, A0, D0); hold(8);

        // R5: short write pulse.
        drive(0, 1, 1, 0, 0, A0, D0); hold(6);
        drive(0, 0, 1, 0, 0, A0, D0); hold(2);
        drive(1, 1, 1, 0, 0, A0, D0); exp_wr++; hold(5);
        expect_now("R5 short pulse", C_IDLE, E_WP);
        hold(6);
        expect_now("R11 error stays set", C_IDLE, E_WP);
        clear_errs("R11 clear");

        // R6: write starts too close.
        drive(0, 1, 1, 0, 0, A0, D0); hold(6);
        drive(0, 0, 1, 0, 0, A0, D0); hold(4);
        drive(0, 1, 1, 0, 0, A0, D0); hold(1);
        drive(0, 0, 1, 0, 0, A0, D0); hold(4);
        drive(1, 1, 1, 0, 0, A0, D0); exp_wr += 2; hold(5);
        expect_now("R6 short write cycle", C_IDLE, E_WC);
        clear_errs("R11 clear after R6");

        // R7: data changes late in the write.
        drive(0, 1, 1, 0, 0, A0, D0); hold(6);
        drive(0, 0, 1, 0, 0, A0, D0); hold(3);
        drive(0, 0, 1, 0, 0, A0, D1); hold(2);
        drive(1, 1, 1, 0, 0, A0, D1); exp_wr++; hold(5);
        expect_now("R7 data setup", C_IDLE, E_DS);
        clear_errs("R11 clear after R7");

        // R8: address changes at write start.
        drive(0, 1, 1, 0, 0, A0, D1); hold(6);
        drive(0, 0, 1, 0, 0, A1, D1); hold(4);
        drive(1, 1, 1, 0, 0, A1, D1); exp_wr++; hold(5);
        expect_now("R8 address setup", C_IDLE, E_AW);
        clear_errs("R11 clear after R8");

        // R9: byte selects change at write start.
        drive(0, 1, 1, 0, 1, A1, D1); hold(6);
        drive(0, 0, 1, 0, 0, A1, D1); hold(4);
        drive(1, 1, 1, 0, 0, A1, D1); exp_wr++; hold(5);
        expect_now("R9 byte select setup", C_IDLE, E_BW);
        clear_errs("R11 clear after R9");

        // R10/R13: legal read cycle with three addresses.
        drive(0, 1, 0, 0, 0, A0, D1); hold(7);
        drive(0, 1, 0, 0, 0, A1, D1); exp_rd++; hold(7);
        drive(0, 1, 0, 0, 0, A2, D1); exp_rd++; hold(7);
        drive(1, 1, 1, 0, 0, A2, D1); exp_rd++; hold(5);
        expect_now("R10 legal read cycle, R13 counts", C_IDLE, E_NONE);

        // R10: one address held too briefly.
        drive(0, 1, 0, 0, 0, A0, D1); hold(6);
        drive(0, 1, 0, 0, 0, A1, D1); exp_rd++; hold(3);
        drive(0, 1, 0, 0, 0, A2, D1); exp_rd++; hold(8);
        drive(1, 1, 1, 0, 0, A2, D1); exp_rd++; hold(5);
        expect_now("R10 short read cycle, R13 counts", C_IDLE, E_RC);

        hold(2);
        finish_run();
    end
endmodule